// File: doc/BRIEF.md
# Port and Interrupt-Window Address Mapper

This block turns two kinds of special access into physical addresses. For an I/O port access it looks at a configuration-address register. When the top bit of that register is set, the access is steered into the configuration-space window. The address is then built from the register's upper bits and the two low bits of the port number. When the top bit is clear, the port number is placed in the flat I/O window.

For an ordinary memory access it checks whether the physical address falls in the one-page local interrupt controller window. The window's base is a page number taken from a base register. A hit marks the access uncacheable and as a memory-mapped register access. It also re-bases the address into a per-core register region, using the core ID and the offset inside the page. A miss passes the address through unchanged.

Each valid request is answered one clock later on registered outputs. The outputs keep their values while no request arrives.

Top module: `spc_addr_mapper`

## Requirements
- R1: After reset, `out_valid`, `map_addr`, `uncache` and `mmreg` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R3: A port request (`is_port`=1) with `cfg_addr[31]`=1 maps to `CFG_PREFIX | {cfg_addr[30:2],2'b00} | port_num[1:0]`. Bits 1:0 of `cfg_addr` have no effect on the result.
- R4: A port request with `cfg_addr[31]`=0 maps to `IO_PREFIX | port_num`, with the port number zero-extended.
- R5: A port request never raises `uncache` or `mmreg`, even when `phys_addr` lies inside the interrupt window.
- R6: A memory request (`is_port`=0) hits when `base_pg*4096 <= phys_addr < base_pg*4096 + 4096`, including when the base is the top page of the address space. A hit raises both `uncache` and `mmreg`.
- R7: On a hit, `map_addr` = `IRQ_PREFIX + core_id*4096 + (phys_addr - base_pg*4096)`.
- R8: A memory request outside the window, including one byte below the base and the first byte past the page, returns `phys_addr` unchanged with both flags low.
- R9: In a cycle after `in_valid` was low, `map_addr`, `uncache` and `mmreg` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| is_port | input | 1 | 1 = I/O port request, 0 = memory request |
| port_num | input | PORT_W (16) | I/O port number |
| cfg_addr | input | CFG_W (32) | Configuration-address register value; top bit enables the config window |
| base_pg | input | PA_W-PG_LG (28) | Interrupt-window base page number |
| phys_addr | input | PA_W (40) | Physical address of a memory request |
| core_id | input | CORE_W (4) | Requesting core |
| out_valid | output | 1 | Result present |
| map_addr | output | PA_W (40) | Mapped physical address |
| uncache | output | 1 | Access must bypass caches |
| mmreg | output | 1 | Access targets a memory-mapped register |

## Verification
Port requests are tried with the enable bit both set and clear, using the same register and port values. This separates the two windows and shows that the register's low two bits are dropped while the port's low two bits are kept. Memory requests are placed at the first and last byte of the window, one byte on either side of it, and in the top page of the address space. These cases tell a correct half-open range test apart from off-by-one and overflowing comparisons. Random requests vary the core ID and the offset to expose errors in the re-basing sum. Idle cycles with changed inputs show that the outputs hold their values.

// File: rtl/spc_map_pkg.sv
package spc_map_pkg;

   typedef enum logic {
      ACC_MEM  = 1'b0,
      ACC_PORT = 1'b1
   } acc_kind_e;

   typedef struct packed {
      logic uncache;
      logic mmreg;
   } map_flags_t;

   localparam map_flags_t FLAGS_NONE = '{uncache: 1'b0, mmreg: 1'b0};
   localparam map_flags_t FLAGS_IRQC = '{uncache: 1'b1, mmreg: 1'b1};

endpackage

// File: rtl/spc_port_router.sv
module spc_port_router #(
   parameter int unsigned          PA_W       = 40,
   parameter int unsigned          PORT_W     = 16,
   parameter int unsigned          CFG_W      = 32,
   parameter logic [PA_W-1:0]      CFG_PREFIX = 40'hC0_0000_0000,
   parameter logic [PA_W-1:0]      IO_PREFIX  = 40'h80_0000_0000
) (
   input  logic [PORT_W-1:0] port_num,
   input  logic [CFG_W-1:0]  cfg_addr,
   output logic [PA_W-1:0]   port_addr
);
   localparam int unsigned EN_BIT = CFG_W - 1;
   localparam int unsigned HI_BIT = CFG_W - 2;

   generate
      if (CFG_W < 4)          begin : g_bad_cfg  $error("CFG_W too small");  end
      if (PA_W < CFG_W)       begin : g_bad_pa   $error("PA_W below CFG_W"); end
      if (PA_W <= PORT_W)     begin : g_bad_port $error("PA_W below PORT_W"); end
      if (PORT_W < 2)         begin : g_bad_pw   $error("PORT_W too small"); end
   endgenerate

   logic [PA_W-1:0] cfg_part;
   logic [PA_W-1:0] lane_part;
   logic [PA_W-1:0] flat_part;

   always_comb begin
      cfg_part              = '0;
      cfg_part[HI_BIT:2]    = cfg_addr[HI_BIT:2];
      lane_part             = '0;
      lane_part[1:0]        = port_num[1:0];
      flat_part             = '0;
      flat_part[PORT_W-1:0] = port_num;
      if (cfg_addr[EN_BIT])
         port_addr = CFG_PREFIX | cfg_part | lane_part;
      else
         port_addr = IO_PREFIX | flat_part;
   end

endmodule

// File: rtl/spc_irqc_window.sv
module spc_irqc_window #(
   parameter int unsigned     PA_W       = 40,
   parameter int unsigned     PG_LG      = 12,
   parameter int unsigned     CORE_W     = 4,
   parameter int unsigned     HIT_STYLE  = 0,
   parameter logic [PA_W-1:0] IRQ_PREFIX = 40'hA0_0000_0000,
   localparam int unsigned    BASE_W     = PA_W - PG_LG
) (
   input  logic [PA_W-1:0]   phys_addr,
   input  logic [BASE_W-1:0] base_pg,
   input  logic [CORE_W-1:0] core_id,
   output logic              hit,
   output logic [PA_W-1:0]   remap
);
   generate
      if (PG_LG < 2)               begin : g_bad_pg   $error("PG_LG too small"); end
      if (PG_LG + CORE_W > PA_W)   begin : g_bad_core $error("core field overflows"); end
      if (HIT_STYLE > 1)           begin : g_bad_sty  $error("HIT_STYLE must be 0 or 1"); end
   endgenerate

   logic [PA_W-1:0]  base_full;
   logic [PG_LG-1:0] offset;
   logic [PA_W-1:0]  off_ext;
   logic [PA_W-1:0]  core_off;

   assign base_full = {base_pg, {PG_LG{1'b0}}};

   generate
      if (HIT_STYLE == 0) begin : g_pgmatch
         // page-number equality: one comparator of BASE_W bits
         assign hit    = (phys_addr[PA_W-1:PG_LG] == base_pg);
         assign offset = phys_addr[PG_LG-1:0];
      end else begin : g_range
         // explicit half-open range with a carry bit for the top page
         logic [PA_W:0]   top_excl;
         logic [PA_W-1:0] diff;
         assign top_excl = {1'b0, base_full} + ({{PA_W{1'b0}}, 1'b1} << PG_LG);
         assign hit      = (phys_addr >= base_full) && ({1'b0, phys_addr} < top_excl);
         assign diff     = phys_addr - base_full;
         assign offset   = diff[PG_LG-1:0];
      end
   endgenerate

   always_comb begin
      off_ext                    = '0;
      off_ext[PG_LG-1:0]         = offset;
      core_off                   = '0;
      core_off[PG_LG +: CORE_W]  = core_id;
      remap                      = IRQ_PREFIX + core_off + off_ext;
   end

endmodule

// File: rtl/spc_map_stage.sv
module spc_map_stage
   import spc_map_pkg::*;
#(
   parameter int unsigned PA_W = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  acc_kind_e       kind,
   input  logic [PA_W-1:0] port_addr,
   input  logic            win_hit,
   input  logic [PA_W-1:0] win_remap,
   input  logic [PA_W-1:0] phys_addr,
   output logic            out_valid,
   output logic [PA_W-1:0] map_addr,
   output map_flags_t      flags
);
   logic [PA_W-1:0] nxt_addr;
   map_flags_t      nxt_flags;

   always_comb begin
      if (kind == ACC_PORT) begin
         nxt_addr  = port_addr;
         nxt_flags = FLAGS_NONE;
      end else if (win_hit) begin
         nxt_addr  = win_remap;
         nxt_flags = FLAGS_IRQC;
      end else begin
         nxt_addr  = phys_addr;
         nxt_flags = FLAGS_NONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         map_addr  <= '0;
         flags     <= FLAGS_NONE;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            map_addr <= nxt_addr;
            flags    <= nxt_flags;
         end
      end
   end

endmodule

// File: rtl/spc_addr_mapper.sv
module spc_addr_mapper
   import spc_map_pkg::*;
#(
   parameter int unsigned     PA_W       = 40,
   parameter int unsigned     PORT_W     = 16,
   parameter int unsigned     CFG_W      = 32,
   parameter int unsigned     CORE_W     = 4,
   parameter int unsigned     PG_LG      = 12,
   parameter int unsigned     HIT_STYLE  = 0,
   parameter logic [PA_W-1:0] CFG_PREFIX = 40'hC0_0000_0000,
   parameter logic [PA_W-1:0] IO_PREFIX  = 40'h80_0000_0000,
   parameter logic [PA_W-1:0] IRQ_PREFIX = 40'hA0_0000_0000,
   localparam int unsigned    BASE_W     = PA_W - PG_LG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              is_port,
   input  logic [PORT_W-1:0] port_num,
   input  logic [CFG_W-1:0]  cfg_addr,
   input  logic [BASE_W-1:0] base_pg,
   input  logic [PA_W-1:0]   phys_addr,
   input  logic [CORE_W-1:0] core_id,
   output logic              out_valid,
   output logic [PA_W-1:0]   map_addr,
   output logic              uncache,
   output logic              mmreg
);
   logic [PA_W-1:0] port_addr;
   logic            win_hit;
   logic [PA_W-1:0] win_remap;
   map_flags_t      flags;
   acc_kind_e       kind;

   assign kind = is_port ? ACC_PORT : ACC_MEM;

   spc_port_router #(
      .PA_W(PA_W), .PORT_W(PORT_W), .CFG_W(CFG_W),
      .CFG_PREFIX(CFG_PREFIX), .IO_PREFIX(IO_PREFIX)
   ) u_port (
      .port_num (port_num),
      .cfg_addr (cfg_addr),
      .port_addr(port_addr)
   );

   spc_irqc_window #(
      .PA_W(PA_W), .PG_LG(PG_LG), .CORE_W(CORE_W),
      .HIT_STYLE(HIT_STYLE), .IRQ_PREFIX(IRQ_PREFIX)
   ) u_win (
      .phys_addr(phys_addr),
      .base_pg  (base_pg),
      .core_id  (core_id),
      .hit      (win_hit),
      .remap    (win_remap)
   );

   spc_map_stage #(.PA_W(PA_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .kind     (kind),
      .port_addr(port_addr),
      .win_hit  (win_hit),
      .win_remap(win_remap),
      .phys_addr(phys_addr),
      .out_valid(out_valid),
      .map_addr (map_addr),
      .flags    (flags)
   );

   assign uncache = flags.uncache;
   assign mmreg   = flags.mmreg;

endmodule

// File: rtl/spc_addr_mapper_chk.sv
module spc_addr_mapper_chk #(
   parameter int unsigned     PA_W       = 40,
   parameter int unsigned     PORT_W     = 16,
   parameter int unsigned     CFG_W      = 32,
   parameter int unsigned     CORE_W     = 4,
   parameter int unsigned     PG_LG      = 12,
   parameter logic [PA_W-1:0] IO_PREFIX  = 40'h80_0000_0000,
   localparam int unsigned    BASE_W     = PA_W - PG_LG
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              is_port,
   input logic [PORT_W-1:0] port_num,
   input logic [CFG_W-1:0]  cfg_addr,
   input logic [BASE_W-1:0] base_pg,
   input logic [PA_W-1:0]   phys_addr,
   input logic [CORE_W-1:0] core_id,
   input logic              out_valid,
   input logic [PA_W-1:0]   map_addr,
   input logic              uncache,
   input logic              mmreg
);
   logic [PA_W-1:0] port_ext;
   logic            pg_match;
   always_comb begin
      port_ext              = '0;
      port_ext[PORT_W-1:0]  = port_num;
   end
   assign pg_match = (phys_addr[PA_W-1:PG_LG] == base_pg);

   p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_cfg_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_port && cfg_addr[CFG_W-1]) |=> (map_addr[1:0] == $past(port_num[1:0])));
   p_io_flat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_port && !cfg_addr[CFG_W-1]) |=> (map_addr == (IO_PREFIX | $past(port_ext))));
   p_port_noflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_port) |=> (!uncache && !mmreg));
   p_hit_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_port && pg_match) |=> (uncache && mmreg));
   p_hit_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_port && pg_match) |=> (map_addr[PG_LG-1:0] == $past(phys_addr[PG_LG-1:0])));
   p_miss_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !is_port && !pg_match) |=> (map_addr == $past(phys_addr) && !uncache && !mmreg));
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(map_addr) && $stable(uncache) && $stable(mmreg)));

endmodule

bind spc_addr_mapper spc_addr_mapper_chk #(
   .PA_W(PA_W), .PORT_W(PORT_W), .CFG_W(CFG_W), .CORE_W(CORE_W),
   .PG_LG(PG_LG), .IO_PREFIX(IO_PREFIX)
) u_chk (.*);

// File: tb/tb_spc_addr_mapper.sv
`timescale 1ns/1ps
module tb_spc_addr_mapper;
   localparam logic [39:0] CFG_P = 40'hC0_0000_0000;
   localparam logic [39:0] IO_P  = 40'h80_0000_0000;
   localparam logic [39:0] IRQ_P = 40'hA0_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        is_port = 1'b0;
   logic [15:0] port_num = '0;
   logic [31:0] cfg_addr = '0;
   logic [27:0] base_pg = '0;
   logic [39:0] phys_addr = '0;
   logic [3:0]  core_id = '0;
   logic        out_valid;
   logic [39:0] map_addr;
   logic        uncache;
   logic        mmreg;

   int n_cmp = 0;
   int n_bad = 0;
   logic [39:0] last_addr;
   logic        last_flag;

   always #2.5 clk = ~clk;

   spc_addr_mapper dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_port(is_port),
      .port_num(port_num), .cfg_addr(cfg_addr), .base_pg(base_pg),
      .phys_addr(phys_addr), .core_id(core_id), .out_valid(out_valid),
      .map_addr(map_addr), .uncache(uncache), .mmreg(mmreg)
   );

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic in_win(input logic [27:0] b, input logic [39:0] pa);
      logic [40:0] lo = {1'b0, b, 12'h000};
      return ({1'b0, pa} >= lo) && ({1'b0, pa} < lo + 41'd4096);
   endfunction

   function automatic logic [39:0] exp_addr(input logic prt, input logic [31:0] cfg,
         input logic [15:0] pn, input logic [27:0] b, input logic [39:0] pa, input logic [3:0] c);
      if (prt) begin
         if (cfg[31]) return CFG_P | {8'h0, cfg & 32'h7FFF_FFFC} | {38'h0, pn[1:0]};
         return IO_P | {24'h0, pn};
      end
      if (in_win(b, pa))
         return IRQ_P + {24'h0, c, 12'h000} + (pa - {b, 12'h000});
      return pa;
   endfunction

   task automatic req(input logic prt, input logic [31:0] cfg, input logic [15:0] pn,
         input logic [27:0] b, input logic [39:0] pa, input logic [3:0] c);
      logic [39:0] ea;
      logic        ef;
      string       tag;
      @(negedge clk);
      in_valid = 1'b1; is_port = prt; cfg_addr = cfg; port_num = pn;
      base_pg = b; phys_addr = pa; core_id = c;
      @(posedge clk); #1;
      ea = exp_addr(prt, cfg, pn, b, pa, c);
      ef = !prt && in_win(b, pa);
      if (prt) tag = cfg[31] ? "R3" : "R4";
      else     tag = ef ? "R7" : "R8";
      check("R2 valid", {39'h0, out_valid}, 40'h1);
      check(tag, map_addr, ea);
      check(prt ? "R5 uncache" : (ef ? "R6 uncache" : "R8 uncache"), {39'h0, uncache}, {39'h0, ef});
      check(prt ? "R5 mmreg"   : (ef ? "R6 mmreg"   : "R8 mmreg"),   {39'h0, mmreg},   {39'h0, ef});
      last_addr = ea; last_flag = ef;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; is_port = ~is_port; phys_addr = ~phys_addr;
      port_num = ~port_num; cfg_addr = ~cfg_addr;
      @(posedge clk); #1;
      check("R2 idle", {39'h0, out_valid}, 40'h0);
      check("R9 addr hold", map_addr, last_addr);
      check("R9 flag hold", {38'h0, uncache, mmreg}, {38'h0, last_flag, last_flag});
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(posedge clk);
      #1;
      check("R1 valid", {39'h0, out_valid}, 40'h0);
      check("R1 addr", map_addr, 40'h0);
      check("R1 flags", {38'h0, uncache, mmreg}, 40'h0);
      @(negedge clk); rst_n = 1'b1;

      // R3: config window, register low bits dropped, port low bits kept
      req(1'b1, 32'h8012_3457, 16'h0CFE, 28'h00FEE00, 40'h00_FEE0_0010, 4'd1);
      check("R3 directed", map_addr, 40'hC0_0012_3456);
      // R4/R5: flat I/O window, phys address in window has no effect
      req(1'b1, 32'h0012_3457, 16'h03F8, 28'h00FEE00, 40'h00_FEE0_0010, 4'd1);
      check("R4 directed", map_addr, 40'h80_0000_03F8);
      idle();
      // R6/R7: first and last byte of window
      req(1'b0, 32'h0, 16'h0, 28'h00FEE00, 40'h00_FEE0_0000, 4'd3);
      check("R7 base", map_addr, 40'hA0_0000_3000);
      req(1'b0, 32'h0, 16'h0, 28'h00FEE00, 40'h00_FEE0_0FFF, 4'd15);
      check("R7 last", map_addr, 40'hA0_0000_FFFF);
      // R8: one below and one past
      req(1'b0, 32'h0, 16'h0, 28'h00FEE00, 40'h00_FEDF_FFFF, 4'd3);
      req(1'b0, 32'h0, 16'h0, 28'h00FEE00, 40'h00_FEE0_1000, 4'd3);
      // R6: top page of the address space
      req(1'b0, 32'h0, 16'h0, 28'hFFF_FFFF, 40'hFF_FFFF_FFF0, 4'd2);
      check("R6 top page", {39'h0, uncache}, 40'h1);
      idle();

      for (int i = 0; i < 3000; i++) begin
         logic        prt = $urandom_range(0, 2) == 0;
         logic [27:0] b   = 28'($urandom);
         logic [39:0] pa  = {8'($urandom), 32'($urandom)};
         case ($urandom_range(0, 3))
            0: pa = {b, 12'($urandom)};
            1: pa = {b, 12'h000} - 40'd1;
            2: pa = {b, 12'hFFF} + 40'd1;
            default: ;
         endcase
         req(prt, 32'($urandom), 16'($urandom), b, pa, 4'($urandom));
         if ($urandom_range(0, 7) == 0) idle();
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule